// File: doc/BRIEF.md
# Configurable Interrupt Trigger Detector

This block watches a vector of interrupt request lines and turns them into a raw pending vector, one bit per source. Every source has its own trigger configuration. It can be level-sensitive, active high or active low. It can also be edge-sensitive, catching rising edges, falling edges or any change. Each request line first passes through a resynchronizing chain. The detector then compares the synchronized level against a stored copy of the previous synchronized level.

A level-mode pending bit simply tracks the qualified input, setting and dropping with it. An edge-mode pending bit is sticky: detection sets it, and only a clear pulse for that source drops it. The surrounding controller does the masking, the routing to outputs and the register decoding. It feeds this block the configuration vectors and the clear vector, and reads back the pending vector and the per-source level history.

Top module: `irq_trigger_detect`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every bit of `pend_o` and `hist_o` is 0.
- R2: A change on `req_i` reaches the block's state after `SYNC_STAGES`+1 rising edges (three with defaults). A value driven just after edge E is reflected in `pend_o` and `hist_o` after edge E+3, and not before.
- R3: With `level_mode_i[i]`=1 and `polarity_i[i]`=1, `pend_o[i]` is 1 exactly while the synchronized input is 1, and 0 otherwise.
- R4: With `level_mode_i[i]`=1 and `polarity_i[i]`=0, `pend_o[i]` is 1 exactly while the synchronized input is 0, and 0 otherwise.
- R5: With `level_mode_i[i]`=0 and `any_edge_i[i]`=1, any difference between the stored previous level and the synchronized level sets `pend_o[i]`, whatever `polarity_i[i]` holds.
- R6: With `level_mode_i[i]`=0, `any_edge_i[i]`=0 and `polarity_i[i]`=1, only a 0-to-1 transition sets `pend_o[i]`.
- R7: With `level_mode_i[i]`=0, `any_edge_i[i]`=0 and `polarity_i[i]`=0, only a 1-to-0 transition sets `pend_o[i]`. A rising transition leaves it 0.
- R8: An edge-mode `pend_o[i]` holds at 1 until a cycle with `clr_i[i]`=1. It reads 0 after that edge if no new edge is detected on the same edge.
- R9: When an edge is detected on the same edge where `clr_i[i]`=1, the set wins and `pend_o[i]` stays 1.
- R10: `clr_i[i]`=1 has no effect on a level-mode source. `pend_o[i]` keeps following its input.
- R11: `hist_o[i]` takes the synchronized input on every edge out of reset, in every mode. It therefore equals the synchronized level one edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_SRC | Interrupt request lines, asynchronous to clk_i |
| level_mode_i | input | NUM_SRC | 1 = level-sensitive source, 0 = edge-sensitive |
| polarity_i | input | NUM_SRC | Level: 1 high-active, 0 low-active. Edge: 1 rising, 0 falling |
| any_edge_i | input | NUM_SRC | Edge mode only: 1 = both edges trigger, overrides polarity |
| clr_i | input | NUM_SRC | One-cycle clear request per source (edge mode only) |
| pend_o | output | NUM_SRC | Raw pending vector |
| hist_o | output | NUM_SRC | Previous synchronized level of each source |

## Verification
The hardest situation to create is an edge detection and a clear for the same source landing on the same clock edge. From the ports it is invisible which edge the detector acts on. The clear must be raised exactly one cycle before the detecting edge, counting through the synchronizer and the history register. The directed stimulus drives a rising request right after a known edge and raises the clear just after the second following edge. A random phase then reshuffles the mode vectors and fires sparse clears while a cycle-accurate model checks every source on every clock.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;

   typedef enum logic [2:0] {
      TM_LVL_HI   = 3'd0,
      TM_LVL_LO   = 3'd1,
      TM_EDGE_ANY = 3'd2,
      TM_EDGE_UP  = 3'd3,
      TM_EDGE_DN  = 3'd4
   } trig_mode_e;

   // The any-edge bit outranks the polarity bit in edge mode.
   function automatic trig_mode_e decode_mode(input logic lvl, input logic pol,
                                              input logic any);
      trig_mode_e m;
      if (lvl)       m = pol ? TM_LVL_HI : TM_LVL_LO;
      else if (any)  m = TM_EDGE_ANY;
      else           m = pol ? TM_EDGE_UP : TM_EDGE_DN;
      return m;
   endfunction

   function automatic logic is_level(input trig_mode_e m);
      return (m == TM_LVL_HI) || (m == TM_LVL_LO);
   endfunction

   function automatic logic edge_hit(input trig_mode_e m, input logic prev,
                                     input logic cur);
      logic h;
      case (m)
         TM_EDGE_ANY: h = prev ^ cur;
         TM_EDGE_UP:  h = ~prev & cur;
         TM_EDGE_DN:  h = prev & ~cur;
         default:     h = 1'b0;
      endcase
      return h;
   endfunction

endpackage

// File: rtl/irq_sync_vec.sv
module irq_sync_vec #(
   parameter int WIDTH  = 51,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   logic [WIDTH-1:0] stg_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) stg_q[s] <= '0;
               else         stg_q[s] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) stg_q[s] <= '0;
               else         stg_q[s] <= stg_q[s-1];
            end
         end
      end
   endgenerate

   assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/irq_trig_cell.sv
module irq_trig_cell
   import irq_trig_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic cur_i,
   input  logic lvl_i,
   input  logic pol_i,
   input  logic any_i,
   input  logic clr_i,
   output logic pend_o,
   output logic hist_o
);

   trig_mode_e mode;
   logic       hist_q;
   logic       pend_q;
   logic       hit;
   logic       lvl_act;
   logic       pend_d;

   always_comb begin
      mode    = decode_mode(lvl_i, pol_i, any_i);
      hit     = edge_hit(mode, hist_q, cur_i);
      lvl_act = (mode == TM_LVL_HI) ? cur_i : ~cur_i;
      if (is_level(mode)) pend_d = lvl_act;
      else                pend_d = (pend_q & ~clr_i) | hit;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hist_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         hist_q <= cur_i;
         pend_q <= pend_d;
      end
   end

   assign pend_o = pend_q;
   assign hist_o = hist_q;

endmodule

// File: rtl/irq_trigger_detect.sv
module irq_trigger_detect #(
   parameter int NUM_SRC     = 51,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] req_i,
   input  logic [NUM_SRC-1:0] level_mode_i,
   input  logic [NUM_SRC-1:0] polarity_i,
   input  logic [NUM_SRC-1:0] any_edge_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] pend_o,
   output logic [NUM_SRC-1:0] hist_o
);

   generate
      if (NUM_SRC < 1) begin : g_bad_width
         $error("irq_trigger_detect: NUM_SRC must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("irq_trigger_detect: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NUM_SRC-1:0] sync_lvl;

   irq_sync_vec #(
      .WIDTH  (NUM_SRC),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (req_i),
      .sync_o  (sync_lvl)
   );

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         irq_trig_cell u_cell (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .cur_i  (sync_lvl[i]),
            .lvl_i  (level_mode_i[i]),
            .pol_i  (polarity_i[i]),
            .any_i  (any_edge_i[i]),
            .clr_i  (clr_i[i]),
            .pend_o (pend_o[i]),
            .hist_o (hist_o[i])
         );
      end
   endgenerate

endmodule

// File: rtl/irq_trigger_detect_chk.sv
module irq_trigger_detect_chk #(
   parameter int NUM_SRC = 51
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic [NUM_SRC-1:0] level_mode_i,
   input logic [NUM_SRC-1:0] polarity_i,
   input logic [NUM_SRC-1:0] any_edge_i,
   input logic [NUM_SRC-1:0] clr_i,
   input logic [NUM_SRC-1:0] sync_lvl,
   input logic [NUM_SRC-1:0] pend_o,
   input logic [NUM_SRC-1:0] hist_o
);

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
         // R11
         hist_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            1'b1 |=> hist_o[i] == $past(sync_lvl[i]));

         // R3
         lvl_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (level_mode_i[i] && polarity_i[i]) |=> pend_o[i] == $past(sync_lvl[i]));

         // R4
         lvl_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (level_mode_i[i] && !polarity_i[i]) |=> pend_o[i] != $past(sync_lvl[i]));

         // R5
         any_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!level_mode_i[i] && any_edge_i[i] && (hist_o[i] != sync_lvl[i]))
            |=> pend_o[i]);

         // R6, R9
         rise_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!level_mode_i[i] && !any_edge_i[i] && polarity_i[i] &&
             !hist_o[i] && sync_lvl[i]) |=> pend_o[i]);

         // R7
         fall_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!level_mode_i[i] && !any_edge_i[i] && !polarity_i[i] &&
             hist_o[i] && !sync_lvl[i]) |=> pend_o[i]);

         // R8
         sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!level_mode_i[i] && pend_o[i] && !clr_i[i]) |=> pend_o[i]);

         // R8
         no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!level_mode_i[i] && (hist_o[i] == sync_lvl[i]) &&
             (clr_i[i] || !pend_o[i])) |=> !pend_o[i]);
      end
   endgenerate

endmodule

bind irq_trigger_detect irq_trigger_detect_chk #(.NUM_SRC(NUM_SRC)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .level_mode_i (level_mode_i),
   .polarity_i   (polarity_i),
   .any_edge_i   (any_edge_i),
   .clr_i        (clr_i),
   .sync_lvl     (sync_lvl),
   .pend_o       (pend_o),
   .hist_o       (hist_o)
);

// File: tb/sim_irq_trigger_detect.sv
module sim_irq_trigger_detect;

   localparam int  NS      = 51;
   localparam time CLK_PER = 10ns;

   logic          clk;
   logic          rst_n;
   logic [NS-1:0] req, lvl, pol, any, clr;
   logic [NS-1:0] pend, hist;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;
   bit cmp_on = 0;

   irq_trigger_detect #(.NUM_SRC(NS), .SYNC_STAGES(2)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .level_mode_i(lvl),
      .polarity_i(pol), .any_edge_i(any), .clr_i(clr),
      .pend_o(pend), .hist_o(hist)
   );

   initial clk = 0;
   always #(CLK_PER/2) clk = ~clk;

   task automatic chk(input bit ok, input string req_tag, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req_tag, act, exp, $time);
      end
   endtask

   // Behavioural reference: queue of sampled request vectors.
   logic [NS-1:0] q[$];
   bit            m_raw [NS];
   bit            m_hist[NS];

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         for (int i = 0; i < NS; i++) begin m_raw[i] = 0; m_hist[i] = 0; end
      end else begin
         for (int i = 0; i < NS; i++) begin
            bit c, p, h;
            c = (q.size() > 1) ? q[1][i] : 1'b0;
            p = (q.size() > 2) ? q[2][i] : 1'b0;
            if (lvl[i]) m_raw[i] = pol[i] ? c : !c;
            else begin
               if (any[i])      h = (c != p);
               else if (pol[i]) h = c && !p;
               else             h = !c && p;
               m_raw[i] = (m_raw[i] && !clr[i]) || h;
            end
            m_hist[i] = c;
         end
         q.push_front(req);
         if (q.size() > 3) void'(q.pop_back());
      end
   end

   function automatic string tag_of(input int i);
      if (lvl[i])      return pol[i] ? "R3" : "R4";
      else if (any[i]) return "R5";
      else             return pol[i] ? "R6" : "R7";
   endfunction

   always @(negedge clk) begin
      if (cmp_on && !done) begin
         int bad_r, bad_h;
         bad_r = -1; bad_h = -1;
         for (int i = 0; i < NS; i++) begin
            if (pend[i] !== m_raw[i]  && bad_r < 0) bad_r = i;
            if (hist[i] !== m_hist[i] && bad_h < 0) bad_h = i;
         end
         if (bad_r >= 0) chk(0, {tag_of(bad_r), " model pend"}, 64'(pend[bad_r]), 64'(m_raw[bad_r]));
         else            chk(1, "", 0, 0);
         if (bad_h >= 0) chk(0, "R11 model hist", 64'(hist[bad_h]), 64'(m_hist[bad_h]));
         else            chk(1, "", 0, 0);
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic wait_edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [NS-1:0] rv();
      logic [63:0] t;
      t = {$urandom(), $urandom()};
      return t[NS-1:0];
   endfunction

   initial begin
      #(CLK_PER * 200000);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 0; req = '0; lvl = '0; pol = '0; any = '0; clr = '0;
      req[7] = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state even with a request high
      chk(pend == '0 && hist == '0, "R1 reset", {pend, 13'd0}, 0);
      cmp_on = 1;
      step();
      rst_n = 1;
      @(negedge clk);
      chk(pend == '0 && hist == '0, "R1 first cycle", 64'(pend), 0);
      req[7] = 1'b0;
      wait_edges(4);

      // R2 / R3: level-high source 0, latency of three edges
      step();
      lvl[0] = 1; pol[0] = 1; req[0] = 1;
      wait_edges(1); chk(pend[0] == 0, "R2 edge1", 64'(pend[0]), 0);
      wait_edges(1); chk(pend[0] == 0, "R2 edge2", 64'(pend[0]), 0);
      wait_edges(1); chk(pend[0] == 1, "R2/R3 edge3", 64'(pend[0]), 1);

      // R10: clear on a level source is ignored
      step(); clr[0] = 1;
      step(); clr[0] = 0;
      @(negedge clk); chk(pend[0] == 1, "R10 level clear ignored", 64'(pend[0]), 1);

      // R6: rising edge on source 1
      pol[1] = 1; req[1] = 1;
      wait_edges(3); chk(pend[1] == 1, "R6 rising set", 64'(pend[1]), 1);
      // R8: sticky after input drops
      step(); req[1] = 0;
      wait_edges(5); chk(pend[1] == 1, "R8 sticky", 64'(pend[1]), 1);
      step(); clr[1] = 1;
      step(); clr[1] = 0;
      @(negedge clk); chk(pend[1] == 0, "R8 cleared", 64'(pend[1]), 0);

      // R9: detection and clear on the same edge
      step(); req[1] = 1;
      @(posedge clk); @(posedge clk); #1 clr[1] = 1;
      @(posedge clk); #1 clr[1] = 0;
      @(negedge clk); chk(pend[1] == 1, "R9 set wins", 64'(pend[1]), 1);

      // R7: falling-only source 2 ignores rise
      step(); req[2] = 1;
      wait_edges(5); chk(pend[2] == 0, "R7 rise ignored", 64'(pend[2]), 0);
      step(); req[2] = 0;
      wait_edges(3); chk(pend[2] == 1, "R7 fall set", 64'(pend[2]), 1);

      // R5: any-edge source 3, polarity irrelevant
      step(); any[3] = 1; pol[3] = 1; req[3] = 1;
      wait_edges(3); chk(pend[3] == 1, "R5 rise", 64'(pend[3]), 1);
      step(); clr[3] = 1;
      step(); clr[3] = 0;
      @(negedge clk); chk(pend[3] == 0, "R5 cleared", 64'(pend[3]), 0);
      step(); req[3] = 0;
      wait_edges(3); chk(pend[3] == 1, "R5 fall", 64'(pend[3]), 1);

      // R4: level-low source 4
      step(); lvl[4] = 1; pol[4] = 0;
      wait_edges(2); chk(pend[4] == 1, "R4 low active", 64'(pend[4]), 1);
      step(); req[4] = 1;
      wait_edges(3); chk(pend[4] == 0, "R4 high inactive", 64'(pend[4]), 0);

      // R11: history follows in level mode too
      chk(hist[4] == 1, "R11 hist level source", 64'(hist[4]), 1);

      // Random phase
      for (int cyc = 0; cyc < 3000; cyc++) begin
         step();
         if (cyc % 60 == 0) begin lvl = rv(); pol = rv(); any = rv(); end
         req = req ^ (rv() & rv() & rv());
         clr = ($urandom_range(3) == 0) ? rv() : '0;
      end
      step(); clr = '0;
      wait_edges(4);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule